// File: doc/BRIEF.md
# Programmable Counter/Timer with Source Select

This block is a 16-bit down-counter for a two-channel serial controller. A 3-bit mode value chooses both the count source and the behaviour. The top bit picks the behaviour: 0 is event counting and 1 is free-running timing. The low two bits pick one of four sources. The possible sources are the external input pin, either channel's 1X transmit clock, the system clock, and divide-by-16 versions of the system clock and of the external pin. The start value comes from two byte-wide preset registers. At each terminal count the counter reloads, emits a one-cycle rate pulse (`ct_tc`), toggles a square-wave output (`ct_clk`) and sets a ready flag. These outputs can feed the per-channel bit-rate clock multiplexers or a general-purpose output pin.

The control state machine has three states:
- ST_IDLE: holds the count.
- ST_COUNT: event counting, started by a command.
- ST_TIMER: free-running timing.

Its transitions are:
- ST_IDLE→ST_TIMER when the mode top bit is 1.
- ST_IDLE→ST_COUNT on a start command.
- ST_COUNT→ST_TIMER when the mode top bit becomes 1.
- ST_COUNT→ST_IDLE on a stop command.
- ST_TIMER→ST_IDLE when the mode top bit returns to 0.
- A self-loop reload in either running state on a start command.

Each entry into a running state loads the preset.

Top module: `ctmr_top`

## Requirements
- R1: After reset, `ct_count` is 0, and `ct_clk`, `ct_tc` and `ct_ready` are all 0.
- R2: In counter mode, only the chosen source decrements the count: 000 is the external pin, 001 is the channel A transmit clock, 010 is the channel B transmit clock, and 011 is the system clock divided by 16.
- R3: In timer mode, the codes map to sources as follows: 100 is the external pin, 101 is the external pin divided by 16, 110 is every system clock cycle, and 111 is the system clock divided by 16.
- R4: Writing a mode with bit 2 set enters ST_TIMER and loads the preset. At each terminal count the counter reloads by itself, and `ct_clk` toggles once every P source ticks.
- R5: In counter mode, a start command loads the preset and counting begins. A stop command returns to ST_IDLE with the count held, and later source edges are ignored.
- R6: `ct_ready` is set at terminal count and cleared by a stop or start command.
- R7: A preset of 0 or 1 is counted as 2, so P = max(preset, 2).
- R8: A preset write changes neither the running count nor the current period. The new value is used at the next reload or start.
- R9: The asynchronous inputs pass through a two-flop synchronizer. Each rising edge counts exactly once, however long the input stays high.
- R10: The write port uses this map:

  | Address | Contents |
  |---|---|
  | 0 | preset high byte |
  | 1 | preset low byte |
  | 2 | mode in bits [2:0] |
  | 3 | command: bit 0 is start, bit 1 is stop |

- R11: `ct_tc` is a single-cycle pulse at each terminal count, so it pulses once per P source ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_in | input | 1 | External count input, asynchronous |
| txc_a | input | 1 | Channel A transmit 1X clock, asynchronous |
| txc_b | input | 1 | Channel B transmit 1X clock, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| ct_clk | output | 1 | Square-wave output, toggles at terminal count |
| ct_tc | output | 1 | One-cycle terminal-count pulse |
| ct_ready | output | 1 | Ready flag |
| ct_count | output | 16 | Present counter value |

## Verification
The bench holds the external pin high for many cycles to catch a design that counts a level instead of an edge, which would show as a count falling by more than one. It pulses the unselected transmit clock and the external pin while another source is chosen. A wrong source decode would move the count where it must hold.

It measures toggle intervals for presets 0 and 1, where a design that loads 0 would stall or wrap through 65536 ticks. It also rewrites the preset mid-period, where a design that loads preset writes immediately would shorten or stretch the current interval. Finally, it counts 16 and 32 external edges in the divided timer mode, to expose a missing prescaler or one that is never cleared at load.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_TIMER = 2'd2
    } ct_state_e;

    typedef enum logic [2:0] {
        MD_C_EXT   = 3'b000,
        MD_C_TXA   = 3'b001,
        MD_C_TXB   = 3'b010,
        MD_C_SYS16 = 3'b011,
        MD_T_EXT   = 3'b100,
        MD_T_EXT16 = 3'b101,
        MD_T_SYS   = 3'b110,
        MD_T_SYS16 = 3'b111
    } ct_mode_e;

    localparam logic [1:0] ADR_PRE_HI = 2'd0;
    localparam logic [1:0] ADR_PRE_LO = 2'd1;
    localparam logic [1:0] ADR_MODE   = 2'd2;
    localparam logic [1:0] ADR_CMD    = 2'd3;
endpackage

// File: rtl/ctmr_sync_edge.sv
module ctmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/ctmr_prescale.sv
module ctmr_prescale #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic in_tick_i,
    output logic tick_o
);
    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (clr_i)
            div_q <= '0;
        else if (in_tick_i)
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end

    assign tick_o = in_tick_i && (div_q == LAST) && !clr_i;

    // R3
    spaced_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/ctmr_regs.sv
module ctmr_regs
    import ctmr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [2*BYTE_W-1:0] preset_o,
    output logic [2:0]        mode_o,
    output logic              start_o,
    output logic              stop_o
);
    logic [BYTE_W-1:0] hi_q, lo_q;
    logic [2:0]        mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            mode_q <= MD_C_EXT;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADR_PRE_HI: hi_q   <= wr_data;
                ADR_PRE_LO: lo_q   <= wr_data;
                ADR_MODE:   mode_q <= wr_data[2:0];
                ADR_CMD:    ;
            endcase
        end
    end

    assign preset_o = {hi_q, lo_q};
    assign mode_o   = mode_q;
    assign start_o  = wr_en && (wr_addr == ADR_CMD) && wr_data[0];
    assign stop_o   = wr_en && (wr_addr == ADR_CMD) && wr_data[1];

    // R10
    preset_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ADR_MODE) |=> $stable(mode_o));
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
    import ctmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic [CNT_W-1:0] preset_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             tick_i,
    output logic             load_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tc_o,
    output logic             ct_clk_o,
    output logic             ready_o
);
    localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(2);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    ct_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, eff_preset;
    logic             clk_q, ready_q, load_d, run;
    logic             timer_sel;

    assign timer_sel  = mode_i[2];
    assign eff_preset = (preset_i < MIN_CNT) ? MIN_CNT : preset_i;
    assign run        = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        load_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (timer_sel) begin
                    state_d = ST_TIMER;
                    load_d  = 1'b1;
                end else if (start_i) begin
                    state_d = ST_COUNT;
                    load_d  = 1'b1;
                end
            end
            ST_COUNT: begin
                if (timer_sel) begin
                    state_d = ST_TIMER;
                    load_d  = 1'b1;
                end else if (stop_i) begin
                    state_d = ST_IDLE;
                end else if (start_i) begin
                    load_d  = 1'b1;
                end
            end
            ST_TIMER: begin
                if (!timer_sel) begin
                    state_d = ST_IDLE;
                end else if (start_i) begin
                    load_d  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign tc_o = run && tick_i && !load_d && (cnt_q <= ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            clk_q   <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            if (load_d) begin
                cnt_q <= eff_preset;
                clk_q <= 1'b0;
            end else if (tc_o) begin
                cnt_q <= eff_preset;
                clk_q <= ~clk_q;
            end else if (run && tick_i) begin
                cnt_q <= cnt_q - 1'b1;
            end

            if (tc_o)
                ready_q <= 1'b1;
            else if (start_i || stop_i)
                ready_q <= 1'b0;
        end
    end

    assign load_o   = load_d;
    assign cnt_o    = cnt_q;
    assign ct_clk_o = clk_q;
    assign ready_o  = ready_q;

    // R7
    cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q >= ONE);
    // R4
    tc_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |=> ct_clk_o != $past(ct_clk_o));
    // R6
    tc_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |=> ready_o);
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !load_d) |=> $stable(cnt_o));
    // R11
    tc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |=> !tc_o);
    // R4
    timer_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TIMER && !timer_sel) |=> state_q == ST_IDLE);
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
    import ctmr_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int PRE_DIV     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_in,
    input  logic          txc_a,
    input  logic          txc_b,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [7:0]    wr_data,
    output logic          ct_clk,
    output logic          ct_tc,
    output logic          ct_ready,
    output logic [15:0]   ct_count
);
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int N_ASYN = 3;

    logic [N_ASYN-1:0] async_in, rise;
    logic [CNT_W-1:0]  preset, cnt;
    logic [2:0]        mode;
    logic              start, stop, load, tick_sel;
    logic              sys16_tick, ext16_tick;

    assign async_in = {txc_b, txc_a, ext_in};

    for (genvar g = 0; g < N_ASYN; g++) begin : g_sync
        ctmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (async_in[g]),
            .rise_o  (rise[g])
        );
    end

    ctmr_prescale #(.DIV(PRE_DIV)) u_pre_sys (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (load),
        .in_tick_i (1'b1),
        .tick_o    (sys16_tick)
    );

    ctmr_prescale #(.DIV(PRE_DIV)) u_pre_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (load),
        .in_tick_i (rise[0]),
        .tick_o    (ext16_tick)
    );

    ctmr_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data[BYTE_W-1:0]),
        .preset_o (preset),
        .mode_o   (mode),
        .start_o  (start),
        .stop_o   (stop)
    );

    always_comb begin
        unique case (mode)
            MD_C_EXT:   tick_sel = rise[0];
            MD_C_TXA:   tick_sel = rise[1];
            MD_C_TXB:   tick_sel = rise[2];
            MD_C_SYS16: tick_sel = sys16_tick;
            MD_T_EXT:   tick_sel = rise[0];
            MD_T_EXT16: tick_sel = ext16_tick;
            MD_T_SYS:   tick_sel = 1'b1;
            MD_T_SYS16: tick_sel = sys16_tick;
            default:    tick_sel = 1'b0;
        endcase
    end

    ctmr_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .preset_i (preset),
        .start_i  (start),
        .stop_i   (stop),
        .tick_i   (tick_sel),
        .load_o   (load),
        .cnt_o    (cnt),
        .tc_o     (ct_tc),
        .ct_clk_o (ct_clk),
        .ready_o  (ct_ready)
    );

    assign ct_count = 16'(cnt);

    // R2
    txb_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_C_TXB && !rise[2] && !load && !ct_tc) |=> $stable(ct_count));
endmodule

// File: tb/ctmr_top_tb.sv
module ctmr_top_tb;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        ext_in = 1'b0, txc_a = 1'b0, txc_b = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        ct_clk, ct_tc, ct_ready;
    logic [15:0] ct_count;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    ctmr_top u_dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_ext(input int hi);
        @(negedge clk); ext_in = 1'b1; idle(hi); ext_in = 1'b0; idle(3);
    endtask
    task automatic pulse_a();
        @(negedge clk); txc_a = 1'b1; idle(3); txc_a = 1'b0; idle(3);
    endtask
    task automatic pulse_b();
        @(negedge clk); txc_b = 1'b1; idle(3); txc_b = 1'b0; idle(3);
    endtask

    task automatic set_preset(input int p);
        wr(2'd0, 8'(p >> 8)); wr(2'd1, 8'(p));
    endtask

    task automatic to_idle();
        wr(2'd2, 8'h0); wr(2'd3, 8'h2); idle(2);
    endtask

    task automatic measure(output int iv);
        logic p;
        int guard;
        iv = 0; guard = 0;
        @(negedge clk); p = ct_clk;
        while (ct_clk == p && guard < 5000) begin @(negedge clk); guard++; end
        p = ct_clk;
        guard = 0;
        while (guard < 5000) begin
            @(negedge clk); iv++; guard++;
            if (ct_clk != p) break;
        end
    endtask

    task automatic t_reset();
        chk(ct_count == 0, "R1 count", ct_count, 0);
        chk(ct_clk == 0 && ct_tc == 0 && ct_ready == 0, "R1 outputs",
            {ct_clk, ct_tc, ct_ready}, 0);
    endtask

    task automatic t_counter_ext();
        set_preset(5); wr(2'd2, 8'h0); wr(2'd3, 8'h1); idle(2);
        chk(ct_count == 5, "R5 start loads", ct_count, 5);
        pulse_ext(12); pulse_ext(3); pulse_ext(3); idle(4);
        chk(ct_count == 2, "R9 one count per edge", ct_count, 2);
        pulse_a(); idle(4);
        chk(ct_count == 2, "R2 txc_a ignored in 000", ct_count, 2);
        pulse_ext(3); pulse_ext(3); idle(4);
        chk(ct_count == 5, "R6 reload at tc", ct_count, 5);
        chk(ct_ready == 1, "R6 ready set", ct_ready, 1);
        pulse_ext(3); idle(4);
        wr(2'd3, 8'h2); idle(2);
        chk(ct_ready == 0, "R6 stop clears ready", ct_ready, 0);
        pulse_ext(3); idle(4);
        chk(ct_count == 4, "R5 stopped holds", ct_count, 4);
    endtask

    task automatic t_counter_tx();
        set_preset(5); wr(2'd2, 8'h2); wr(2'd3, 8'h1); idle(2);
        pulse_b(); pulse_b(); idle(4);
        chk(ct_count == 3, "R2 txc_b counts in 010", ct_count, 3);
        pulse_ext(3); pulse_a(); idle(4);
        chk(ct_count == 3, "R2 others ignored in 010", ct_count, 3);
        wr(2'd2, 8'h1); pulse_a(); idle(4);
        chk(ct_count == 2, "R2 txc_a counts in 001", ct_count, 2);
        to_idle();
    endtask

    task automatic t_counter_sys16();
        int iv;
        set_preset(3); wr(2'd2, 8'h3); wr(2'd3, 8'h1);
        measure(iv);
        chk(iv == 48, "R2 sys/16 interval", iv, 48);
        to_idle();
    endtask

    task automatic t_timer_sys();
        int iv, tcs;
        set_preset(4); wr(2'd2, 8'h6);
        measure(iv);
        chk(iv == 4, "R4 timer interval", iv, 4);
        chk(ct_ready == 1, "R6 ready in timer", ct_ready, 1);
        tcs = 0;
        for (int i = 0; i < 12; i++) begin @(negedge clk); if (ct_tc) tcs++; end
        chk(tcs == 3, "R11 tc pulses per 12 ticks", tcs, 3);
        wr(2'd2, 8'h7);
        to_idle();
        set_preset(2); wr(2'd2, 8'h7);
        measure(iv);
        chk(iv == 32, "R3 timer sys/16 interval", iv, 32);
        to_idle();
    endtask

    task automatic t_timer_ext();
        set_preset(3); wr(2'd2, 8'h4); idle(2);
        pulse_ext(3); pulse_ext(3); idle(4);
        chk(ct_clk == 0, "R3 no toggle before 3 edges", ct_clk, 0);
        pulse_ext(3); idle(4);
        chk(ct_clk == 1, "R3 toggle after 3 edges", ct_clk, 1);
        to_idle();
        set_preset(2); wr(2'd2, 8'h5); idle(2);
        for (int i = 0; i < 16; i++) pulse_ext(3);
        idle(4);
        chk(ct_count == 1 && ct_clk == 0, "R3 ext/16 one tick", ct_count, 1);
        for (int i = 0; i < 16; i++) pulse_ext(3);
        idle(4);
        chk(ct_clk == 1, "R3 ext/16 toggle", ct_clk, 1);
        to_idle();
    endtask

    task automatic t_min_preset();
        int iv;
        set_preset(0); wr(2'd2, 8'h6);
        measure(iv);
        chk(iv == 2, "R7 preset 0", iv, 2);
        to_idle();
        set_preset(1); wr(2'd2, 8'h6);
        measure(iv);
        chk(iv == 2, "R7 preset 1", iv, 2);
        to_idle();
    endtask

    task automatic t_preset_defer();
        int iv;
        set_preset(10); wr(2'd2, 8'h6);
        measure(iv);
        chk(iv == 10, "R8 initial interval", iv, 10);
        wr(2'd1, 8'd30);
        chk(ct_count <= 10, "R8 running count untouched", ct_count, 10);
        measure(iv);
        chk(iv == 30, "R8 new preset at reload", iv, 30);
        to_idle();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_counter_ext();
        t_counter_tx();
        t_counter_sys16();
        t_timer_sys();
        t_timer_ext();
        t_min_preset();
        t_preset_defer();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule